// File: doc/BRIEF.md
# Binary-Search Oscillator Frequency Calibrator

This block is the digital core of an integer frequency-locked loop. It sets the capacitor-bank control word of a digitally controlled oscillator so that the oscillator runs as close as possible to a target channel frequency. A start pulse begins a successive-approximation search. The search tries one bank bit per step, from the most significant bit down to the least significant bit. For each trial word the block counts oscillator edges over a window of system-clock cycles. It keeps the bit when the count does not exceed the target count scaled to that window.

Finer bits change the frequency by smaller amounts, so their windows are longer. The window for a bit is a base length doubled once per step below the top bit, up to a maximum shift. Once the last bit is decided, the block measures two words over the longest window: the resulting word and the word one step above it. It keeps whichever has the smaller residual error, then raises a one-cycle lock pulse and holds the word until the next start.

The oscillator edge input must already be synchronous to the system clock. It carries at most one edge per cycle, given as a one-cycle high level.

Top module: `dco_fll_cal`

## Requirements
- R1: While rst_n is low, cap_word is 0 and lock and busy are 0.
- R2: A start seen high at a clock edge captures target_cnt for the whole search. From the next cycle busy is 1 and cap_word is the top-bit trial (only bit CAP_W-1 set). Changes to target_cnt after that edge have no effect on the result.
- R3: Bits are decided from bit CAP_W-1 down to bit 0. The trial bit is set, and it is kept when the edge count is less than or equal to target_cnt shifted left by the bit's shift. Otherwise it is cleared. For an oscillator whose frequency rises with the word, the search result is the largest word whose scaled count does not exceed the scaled target, or 0 if no word qualifies.
- R4: Bit k is judged over BASE_CYC << s cycles, where s = min(CAP_W-1-k, MAX_SHIFT). Counting starts at the edge after the trial word appears on cap_word. Each step costs its window plus one decision cycle, so lock rises a fixed number of cycles after start. With the defaults this is 375 cycles, or 245 when the search result is all ones.
- R5: When the search result w is not all ones, w and w+1 are each counted over the bit-0 window. The block takes w+1 only when its absolute error against the scaled target is strictly smaller than that of w. A tie keeps w. When w is all ones, no refinement takes place.
- R6: lock is high for exactly one cycle. In that cycle busy is already 0 and cap_word carries the final word. The word then stays unchanged until the next start.
- R7: A start during a search abandons that search and begins a new one with the newly captured target. This also applies when the start falls at the edge where lock would have risen; lock is then not raised.
- R8: The edge counter saturates at 2^CNT_W-1 instead of wrapping. The saturated value is the value compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin or restart a calibration |
| dco_edge | input | 1 | Synchronized oscillator edge, one per high cycle |
| target_cnt | input | TGT_W | Expected edges per base window |
| cap_word | output | CAP_W | Capacitor-bank control word |
| lock | output | 1 | One-cycle pulse when calibration completes |
| busy | output | 1 | High while a search is in progress |

## Verification
Two events can fall in the same clock edge: a new start and the final decision that would raise lock. The bench first computes a run's latency arithmetically. It then times a second start so that it is sampled exactly at the lock edge. It expects lock to stay low, busy to stay high and cap_word to return to the top-bit trial, and it expects the later result to follow the second target. An earlier start in mid-search is also tested, and the restarted run's result and latency are judged against the arithmetic model.

// File: rtl/cal_pkg.sv
// Shared types for the oscillator calibrator.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package cal_pkg;

    // Controller phases: idle, bit search, lower and upper final measurements.
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SEARCH = 2'd1,
        S_FIN_LO = 2'd2,
        S_FIN_HI = 2'd3
    } cal_state_t;

endpackage

// File: rtl/cal_window.sv
// Window selector: maps a bank bit index to its count shift and window length.
// Bit k uses shift min(CAP_W-1-k, MAX_SHIFT), window BASE_CYC << shift.
// Assumes CAP_W >= 2 and that bit_idx stays below CAP_W.
module cal_window #(
    parameter int CAP_W     = 5,
    parameter int BASE_CYC  = 16,
    parameter int MAX_SHIFT = 2,
    parameter int IDX_W     = 3,
    parameter int SH_W      = 2,
    parameter int TMR_W     = 7
) (
    input  logic [IDX_W-1:0] bit_idx,
    output logic [SH_W-1:0]  shift,
    output logic [TMR_W-1:0] win_len
);

    logic [SH_W-1:0] sh_tab [CAP_W];

    // Per-bit shift table, fixed at elaboration.
    for (genvar k = 0; k < CAP_W; k++) begin : g_tab
        localparam int RAW = CAP_W - 1 - k;
        localparam int SH  = (RAW > MAX_SHIFT) ? MAX_SHIFT : RAW;
        assign sh_tab[k] = SH_W'(SH);
    end

    // Look up the shift and derive the window length.
    always_comb begin
        shift   = sh_tab[bit_idx];
        win_len = TMR_W'(BASE_CYC) << shift;
    end

endmodule

// File: rtl/cal_counter.sv
// Windowed edge counter. A load pulse clears the count and arms a window of
// win_len samples, taken at the following win_len clock edges. The count
// saturates at all ones. done is high for the one cycle after the last sample.
// Assumes edge_in is synchronous to clk.
module cal_counter #(
    parameter int CNT_W = 12,
    parameter int TMR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] win_len,
    input  logic             edge_in,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             done
);

    logic [TMR_W-1:0] tmr_q;
    logic             last_sample;

    // Flag the final sample of the armed window.
    always_comb last_sample = active && (tmr_q == TMR_W'(1));

    // Window timer and activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            active <= 1'b0;
        end else if (load) begin
            tmr_q  <= win_len;
            active <= 1'b1;
        end else if (active) begin
            tmr_q  <= tmr_q - TMR_W'(1);
            active <= !last_sample;
        end
    end

    // Saturating accumulation of oscillator edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (active && edge_in && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // One-cycle completion strobe, cancelled by a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= !load && last_sample;
        end
    end

endmodule

// File: rtl/cal_judge.sv
// Count judge: scales the target to the window and compares it with the count.
// It reports whether the count overshoots and the absolute residual.
// Assumes EXT_W exceeds both CNT_W and TGT_W + the largest shift.
module cal_judge #(
    parameter int CNT_W = 12,
    parameter int TGT_W = 8,
    parameter int SH_W  = 2,
    parameter int EXT_W = 13
) (
    input  logic [TGT_W-1:0] tgt,
    input  logic [SH_W-1:0]  shift,
    input  logic [CNT_W-1:0] cnt,
    output logic             over,
    output logic [EXT_W-1:0] err
);

    logic [EXT_W-1:0] tgt_scaled;
    logic [EXT_W-1:0] cnt_ext;

    // Widen, scale and compare; the residual is always non-negative.
    always_comb begin
        tgt_scaled = EXT_W'(tgt) << shift;
        cnt_ext    = EXT_W'(cnt);
        over       = cnt_ext > tgt_scaled;
        err        = over ? (cnt_ext - tgt_scaled) : (tgt_scaled - cnt_ext);
    end

endmodule

// File: rtl/dco_fll_cal.sv
// Binary-search oscillator calibrator (top). A start pulse runs a successive
// approximation over the capacitor-bank word, MSB first. Each trial word is
// judged by a windowed edge count whose window grows for finer bits. A final
// neighbour comparison then picks the closer of w and w+1, and lock pulses
// once. Assumes dco_edge is already synchronized to clk and that the
// oscillator frequency rises with the word.
module dco_fll_cal #(
    parameter int CAP_W     = 5,
    parameter int BASE_CYC  = 16,
    parameter int MAX_SHIFT = 2,
    parameter int TGT_W     = 8,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dco_edge,
    input  logic [TGT_W-1:0] target_cnt,
    output logic [CAP_W-1:0] cap_word,
    output logic             lock,
    output logic             busy
);
    import cal_pkg::*;

    localparam int IDX_W = (CAP_W > 1) ? $clog2(CAP_W) : 1;
    localparam int SH_W  = $clog2(MAX_SHIFT + 2);
    localparam int TMR_W = $clog2((BASE_CYC << MAX_SHIFT) + 1);
    localparam int EXT_W = ((CNT_W > TGT_W + MAX_SHIFT) ? CNT_W : (TGT_W + MAX_SHIFT)) + 1;
    localparam logic [CAP_W-1:0] ONE = CAP_W'(1);
    localparam logic [CAP_W-1:0] MSB_TRIAL = ONE << (CAP_W - 1);

    cal_state_t       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [TGT_W-1:0] tgt_q, tgt_n;
    logic [CAP_W-1:0] cap_q, cap_n;
    logic [SH_W-1:0]  sh_q, sh_n;
    logic [EXT_W-1:0] err_lo_q, err_lo_n;
    logic             lock_q, lock_n;

    logic             cnt_load;
    logic [IDX_W-1:0] win_idx;
    logic [SH_W-1:0]  win_shift;
    logic [TMR_W-1:0] win_len;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_active;
    logic             cnt_done;
    logic             over;
    logic [EXT_W-1:0] err;
    logic [CAP_W-1:0] kept;

    cal_window #(
        .CAP_W(CAP_W), .BASE_CYC(BASE_CYC), .MAX_SHIFT(MAX_SHIFT),
        .IDX_W(IDX_W), .SH_W(SH_W), .TMR_W(TMR_W)
    ) u_win (
        .bit_idx(win_idx),
        .shift  (win_shift),
        .win_len(win_len)
    );

    cal_counter #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .win_len(win_len),
        .edge_in(dco_edge),
        .cnt    (cnt_val),
        .active (cnt_active),
        .done   (cnt_done)
    );

    cal_judge #(.CNT_W(CNT_W), .TGT_W(TGT_W), .SH_W(SH_W), .EXT_W(EXT_W)) u_judge (
        .tgt  (tgt_q),
        .shift(sh_q),
        .cnt  (cnt_val),
        .over (over),
        .err  (err)
    );

    // Trial word with the bit under test cleared when its count overshoots.
    always_comb kept = over ? (cap_q & ~(ONE << idx_q)) : cap_q;

    // Next-state logic; a start takes priority over any pending decision.
    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        tgt_n    = tgt_q;
        cap_n    = cap_q;
        sh_n     = sh_q;
        err_lo_n = err_lo_q;
        lock_n   = 1'b0;
        cnt_load = 1'b0;
        win_idx  = '0;
        if (start) begin
            state_n  = S_SEARCH;
            idx_n    = IDX_W'(CAP_W - 1);
            tgt_n    = target_cnt;
            cap_n    = MSB_TRIAL;
            win_idx  = IDX_W'(CAP_W - 1);
            sh_n     = win_shift;
            cnt_load = 1'b1;
        end else if (cnt_done) begin
            unique case (state_q)
                S_SEARCH: begin
                    if (idx_q != '0) begin
                        win_idx  = idx_q - IDX_W'(1);
                        idx_n    = win_idx;
                        cap_n    = kept | (ONE << win_idx);
                        sh_n     = win_shift;
                        cnt_load = 1'b1;
                    end else if (&kept) begin
                        cap_n   = kept;
                        state_n = S_IDLE;
                        lock_n  = 1'b1;
                    end else begin
                        cap_n    = kept;
                        state_n  = S_FIN_LO;
                        sh_n     = win_shift;
                        cnt_load = 1'b1;
                    end
                end
                S_FIN_LO: begin
                    err_lo_n = err;
                    cap_n    = cap_q + ONE;
                    state_n  = S_FIN_HI;
                    sh_n     = win_shift;
                    cnt_load = 1'b1;
                end
                S_FIN_HI: begin
                    cap_n   = (err < err_lo_q) ? cap_q : (cap_q - ONE);
                    state_n = S_IDLE;
                    lock_n  = 1'b1;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // Controller state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            tgt_q    <= '0;
            cap_q    <= '0;
            sh_q     <= '0;
            err_lo_q <= '0;
            lock_q   <= 1'b0;
        end else begin
            state_q  <= state_n;
            idx_q    <= idx_n;
            tgt_q    <= tgt_n;
            cap_q    <= cap_n;
            sh_q     <= sh_n;
            err_lo_q <= err_lo_n;
            lock_q   <= lock_n;
        end
    end

    // Output mapping.
    always_comb begin
        cap_word = cap_q;
        lock     = lock_q;
        busy     = (state_q != S_IDLE);
    end

endmodule

// File: rtl/cal_checks.sv
// Temporal checks for dco_fll_cal, attached by bind. Observes the top ports
// and the edge counter's outputs; drives nothing.
module cal_checks #(
    parameter int CAP_W = 5,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             lock,
    input logic [CAP_W-1:0] cap_word,
    input logic             cnt_load,
    input logic             cnt_active,
    input logic [CNT_W-1:0] cnt_val
);

    localparam logic [CAP_W-1:0] MSB_TRIAL = CAP_W'(1) << (CAP_W - 1);

    // R6: lock never lasts two cycles.
    p_lock_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !lock);

    // R6: lock and busy are never high together.
    p_lock_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock && busy));

    // R6: an idle block without start keeps its word.
    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cap_word));

    // R2 / R7: every start, even mid-search, yields the top-bit trial without lock.
    p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !lock && cap_word == MSB_TRIAL));

    // R8: within a window the count never falls, so it cannot wrap.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_active && !cnt_load) |=> (cnt_val >= $past(cnt_val)));

endmodule

bind dco_fll_cal cal_checks #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .lock      (lock),
    .cap_word  (cap_word),
    .cnt_load  (cnt_load),
    .cnt_active(cnt_active),
    .cnt_val   (cnt_val)
);

// File: tb/tb_dco_fll_cal.sv
// Bench: periodic oscillator models (period 16 cycles, e(c) edges per period)
// make every window count exact, so results and latencies are computed here.
module tb_dco_fll_cal;

    localparam int CW   = 5;
    localparam int TW   = 8;
    localparam int MSBW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_s = 1'b0;
    logic [TW-1:0] tgt = '0;
    logic dco_a = 1'b0, dco_s = 1'b0;
    logic [CW-1:0] cap_a, cap_s;
    logic lock_a, lock_s, busy_a, busy_s;
    logic [3:0] ph = 4'd0;
    int model_a = 0;
    int sel = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dco_fll_cal dut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .dco_edge(dco_a),
        .target_cnt(tgt), .cap_word(cap_a), .lock(lock_a), .busy(busy_a)
    );

    dco_fll_cal #(.CNT_W(5)) dut_sat (
        .clk(clk), .rst_n(rst_n), .start(start_s), .dco_edge(dco_s),
        .target_cnt(tgt), .cap_word(cap_s), .lock(lock_s), .busy(busy_s)
    );

    function automatic int e_of(int m, int c);
        case (m)
            0:       return c >> 1;
            1:       return 2 * (c >> 2);
            default: return 3 * (c >> 3);
        endcase
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int iabs(int a);
        return (a < 0) ? -a : a;
    endfunction

    // Arithmetic model of the requirements: result word and start-to-lock latency.
    function automatic int ref_word(int m, int t, int cmax, output int lat);
        int w = 0;
        lat = 0;
        for (int k = CW - 1; k >= 0; k--) begin
            int sh = imin(CW - 1 - k, 2);
            int tr = w | (1 << k);
            int c  = imin(e_of(m, tr) << sh, cmax);
            if (c <= (t << sh)) w = tr;
            lat += (16 << sh) + 1;
        end
        if (w != 31) begin
            int c0 = imin(e_of(m, w) << 2, cmax);
            int c1 = imin(e_of(m, w + 1) << 2, cmax);
            lat += 2 * 65;
            if (iabs(c1 - (t << 2)) < iabs(c0 - (t << 2))) w = w + 1;
        end
        return w;
    endfunction

    // Oscillator models, updated away from the active edge.
    always @(negedge clk) begin
        dco_a <= (int'(ph) < e_of(model_a, int'(cap_a)));
        dco_s <= (int'(ph) < e_of(0, int'(cap_s)));
        ph    <= ph + 4'd1;
    end

    function automatic int cur_cap();  return sel ? int'(cap_s) : int'(cap_a); endfunction
    function automatic int cur_lock(); return sel ? int'(lock_s) : int'(lock_a); endfunction
    function automatic int cur_busy(); return sel ? int'(busy_s) : int'(busy_a); endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pulse start for one cycle; returns just after the sampling edge.
    task automatic pulse(int t);
        @(negedge clk);
        tgt = TW'(t);
        if (sel != 0) start_s = 1'b1; else start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        start_s = 1'b0;
        check_eq("R2", "busy after start", cur_busy(), 1);
        check_eq("R2", "top-bit trial", cur_cap(), MSBW);
    endtask

    // Wait out the computed latency and judge completion.
    task automatic finish_run(int exp_w, int lat, string req);
        repeat (lat - 1) @(negedge clk);
        check_eq("R4", "no lock before latency", cur_lock(), 0);
        check_eq("R4", "busy until latency", cur_busy(), 1);
        @(negedge clk);
        check_eq("R4", "lock at latency", cur_lock(), 1);
        check_eq("R6", "busy low with lock", cur_busy(), 0);
        check_eq(req, "final word", cur_cap(), exp_w);
        @(negedge clk);
        check_eq("R6", "lock one cycle", cur_lock(), 0);
        repeat (3) @(negedge clk);
        check_eq("R6", "word held", cur_cap(), exp_w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, w, lat2, w2;
        repeat (3) @(negedge clk);
        check_eq("R1", "reset word", int'(cap_a), 0);
        check_eq("R1", "reset lock", int'(lock_a), 0);
        check_eq("R1", "reset busy", int'(busy_a), 0);
        check_eq("R1", "reset busy sat", int'(busy_s), 0);
        rst_n = 1'b1;

        // R3 R5: sweep all targets over three oscillator models.
        sel = 0;
        for (int m = 0; m < 3; m++) begin
            for (int t = 0; t <= 16; t++) begin
                model_a = m;
                w = ref_word(m, t, 4095, lat);
                pulse(t);
                finish_run(w, lat, (w == 31) ? "R5 all-ones" : "R3 R5");
            end
        end

        // R8: saturating counter instance, model 0, all targets.
        sel = 1;
        for (int t = 0; t <= 16; t++) begin
            w = ref_word(0, t, 31, lat);
            pulse(t);
            finish_run(w, lat, "R8");
        end

        // R2: target changes after start are ignored.
        sel = 0;
        model_a = 0;
        w = ref_word(0, 5, 4095, lat);
        pulse(5);
        repeat (50) @(negedge clk);
        tgt = TW'(12);
        finish_run(w, lat - 50, "R2");

        // R7: restart in mid-search.
        pulse(3);
        repeat (100) @(negedge clk);
        w = ref_word(0, 11, 4095, lat);
        pulse(11);
        finish_run(w, lat, "R7");

        // R7: start sampled at the very edge where lock would rise.
        w = ref_word(0, 9, 4095, lat);
        w2 = ref_word(0, 2, 4095, lat2);
        pulse(9);
        repeat (lat - 1) @(negedge clk);
        tgt = TW'(2);
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        check_eq("R7", "lock suppressed", int'(lock_a), 0);
        check_eq("R7", "still busy", int'(busy_a), 1);
        check_eq("R7", "restart trial", int'(cap_a), MSBW);
        finish_run(w2, lat2, "R7");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule